// File: doc/BRIEF.md
# Scrolling LED Matrix Display Controller

This block drives one 16x16 LED dot matrix from glyph bitmaps held in an external byte-wide memory. It reads glyph data two bytes at a time, joins them into a 16-bit row word, and lights one LED row at a time through a one-hot row-select output while the row word sits on the column output. Each glyph takes 32 bytes: one pair of bytes for every pixel row.

A slow scroll tick, synchronous to the fetch clock, advances a modulo-16 scroll offset. The glyph-row counter only runs from zero up to the current offset, and each glyph row n is shown on LED row n + (15 - offset). So at offset 0 only glyph row 0 is visible, on the last LED row. As the offset climbs, the glyph slides in row by row until all sixteen rows show. When the offset wraps from 15 back to 0, the character index steps to the next glyph.

Top module: `led_scroll_ctrl`

## Requirements
- R1: While reset (rst_n low at a clock edge, synchronous) is applied, rd_n is 1, mem_addr is 0, row_sel is 0 and col_data is 0.
- R2: From the second cycle after reset, mem_addr bit 0 alternates every cycle: 0 (low byte) first, then 1 (high byte). The two reads form one fetch pair.
- R3: mem_addr bits 4..1 hold the glyph row. It starts at 0. At the end of each pair it returns to 0 if it is greater than or equal to the scroll offset, and otherwise it increases by 1.
- R4: Each scroll_tick pulse is remembered until the end of the next fetch pair (or the current one, if it ends in that cycle). There it raises the scroll offset by 1, modulo 16, and sets the glyph row to 0.
- R5: mem_addr bits 9..5 hold the character index. It starts at 0 and rises by 1, modulo 32, when the scroll offset wraps from 15 to 0.
- R6: At the end of a fetch pair, col_data takes the high byte in bits 15..8 and the low byte in bits 7..0. It takes this value at the same clock edge as row_sel and holds it until the next pair ends.
- R7: At the end of a fetch pair, row_sel becomes one-hot at bit (glyph row + 15 - offset) mod 16, using the glyph row and offset of that pair. At offset 0 only bit 15 is ever lit. At offset k, exactly bits 15-k..15 are lit over a scroll period.
- R8: row_sel has at most one bit set at any time, and stays 0 until the first fetch pair after reset ends.
- R9: rd_n goes low one cycle after reset is released and stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fetch and scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scroll_tick | input | 1 | One-cycle pulse that advances the scroll offset |
| mem_data | input | BYTE_W (8) | Byte read from glyph memory at mem_addr |
| rd_n | output | 1 | Active-low memory read strobe |
| mem_addr | output | CHAR_W+5 (10) | Byte address: character, glyph row, byte select |
| row_sel | output | 16 | One-hot LED row enable |
| col_data | output | 2*BYTE_W (16) | Row word driven onto the LED columns |

## Verification
The bench builds the block with its default values: 5 character-index bits and 8-bit bytes. It drives it through 528 scroll ticks, which is 33 full offset sweeps. That number carries the character index past its 31-to-0 wrap, and every offset from 0 to 15 stays in force long enough for the glyph-row counter to cover its whole range. Tick spacing varies from tick to tick, so pulses land in both the low-byte and high-byte cycle of a fetch pair. This exercises the held-tick path. The lit rows are gathered per offset and compared with the expected band of rows.

// File: rtl/led_scroll_pkg.sv
package led_scroll_pkg;
  localparam int ROW_W = 4;
  localparam int ROWS  = 1 << ROW_W;

  typedef logic [ROW_W-1:0] row_t;

  // Glyph-row step at the end of a fetch pair.
  function automatic row_t next_glyph_row(row_t g, row_t off);
    return (g >= off) ? '0 : row_t'(g + 1'b1);
  endfunction

  // LED row on which glyph row g is shown for a given scroll offset.
  function automatic row_t led_row(row_t g, row_t off);
    return row_t'(g + (row_t'(ROWS - 1) - off));
  endfunction

  function automatic logic [ROWS-1:0] row_onehot(row_t r);
    logic [ROWS-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/lsc_fetch_seq.sv
module lsc_fetch_seq (
  input  logic clk,
  input  logic rst_n,
  output logic active,
  output logic byte_hi,
  output logic pair_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      byte_hi <= 1'b0;
    end else begin
      active <= 1'b1;
      if (active) byte_hi <= ~byte_hi;
    end
  end

  assign pair_done = active & byte_hi;
endmodule

// File: rtl/lsc_scroll.sv
module lsc_scroll
  import led_scroll_pkg::*;
#(
  parameter int CHAR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scroll_tick,
  input  logic              pair_done,
  output row_t              glyph_row,
  output row_t              offset,
  output logic [CHAR_W-1:0] char_idx
);
  logic pend;
  logic tick_any;

  assign tick_any = pend | scroll_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      glyph_row <= '0;
      offset    <= '0;
      char_idx  <= '0;
    end else if (pair_done) begin
      if (tick_any) begin
        pend      <= 1'b0;
        offset    <= row_t'(offset + 1'b1);
        glyph_row <= '0;
        if (offset == row_t'(ROWS - 1)) char_idx <= char_idx + 1'b1;
      end else begin
        glyph_row <= next_glyph_row(glyph_row, offset);
      end
    end else begin
      pend <= tick_any;
    end
  end
endmodule

// File: rtl/lsc_row_out.sv
module lsc_row_out
  import led_scroll_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                byte_hi,
  input  logic                pair_done,
  input  logic [BYTE_W-1:0]   mem_data,
  input  row_t                glyph_row,
  input  row_t                offset,
  output logic [ROWS-1:0]     row_sel,
  output logic [2*BYTE_W-1:0] col_data
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      row_sel  <= '0;
      col_data <= '0;
    end else begin
      if (active && !byte_hi) lo_q <= mem_data;
      if (pair_done) begin
        col_data <= {mem_data, lo_q};
        row_sel  <= row_onehot(led_row(glyph_row, offset));
      end
    end
  end
endmodule

// File: rtl/led_scroll_ctrl.sv
module led_scroll_ctrl
  import led_scroll_pkg::*;
#(
  parameter int CHAR_W = 5,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = CHAR_W + ROW_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scroll_tick,
  input  logic [BYTE_W-1:0]   mem_data,
  output logic                rd_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ROWS-1:0]     row_sel,
  output logic [2*BYTE_W-1:0] col_data
);
  logic              active;
  logic              byte_hi;
  logic              pair_done;
  row_t              glyph_row;
  row_t              offset;
  logic [CHAR_W-1:0] char_idx;

  lsc_fetch_seq u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .byte_hi   (byte_hi),
    .pair_done (pair_done)
  );

  lsc_scroll #(.CHAR_W(CHAR_W)) u_scroll (
    .clk         (clk),
    .rst_n       (rst_n),
    .scroll_tick (scroll_tick),
    .pair_done   (pair_done),
    .glyph_row   (glyph_row),
    .offset      (offset),
    .char_idx    (char_idx)
  );

  lsc_row_out #(.BYTE_W(BYTE_W)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .byte_hi   (byte_hi),
    .pair_done (pair_done),
    .mem_data  (mem_data),
    .glyph_row (glyph_row),
    .offset    (offset),
    .row_sel   (row_sel),
    .col_data  (col_data)
  );

  assign rd_n     = ~active;
  assign mem_addr = {char_idx, glyph_row, byte_hi};
endmodule

// File: rtl/led_scroll_chk.sv
module led_scroll_chk
  import led_scroll_pkg::*;
#(
  parameter int CHAR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              addr_b0,
  input logic [ROWS-1:0]   row_sel,
  input logic              pair_done,
  input row_t              glyph_row,
  input row_t              offset,
  input logic [CHAR_W-1:0] char_idx
);
  assert_strobe_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_n)) |-> !rd_n);

  assert_byte_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_n) && !rd_n) |-> (addr_b0 != $past(addr_b0)));

  assert_row_within_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_row <= offset);

  assert_char_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (char_idx != $past(char_idx)))
      |-> ($past(offset) == row_t'(ROWS - 1) && offset == '0));

  assert_single_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  assert_rowsel_only_on_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pair_done)) |-> $stable(row_sel));
endmodule

bind led_scroll_ctrl led_scroll_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_n      (rd_n),
  .addr_b0   (mem_addr[0]),
  .row_sel   (row_sel),
  .pair_done (pair_done),
  .glyph_row (glyph_row),
  .offset    (offset),
  .char_idx  (char_idx)
);

// File: tb/led_scroll_ctrl_tb.sv
module led_scroll_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scroll_tick = 1'b0;
  logic [7:0]  mem_data;
  logic        rd_n;
  logic [9:0]  mem_addr;
  logic [15:0] row_sel;
  logic [15:0] col_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(logic [9:0] a);
    logic [9:0] t;
    t = (a * 10'd29) ^ (a >> 2);
    return t[7:0] ^ {6'b0, t[9:8]};
  endfunction

  assign mem_data = memf(mem_addr);

  led_scroll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scroll_tick(scroll_tick), .mem_data(mem_data),
    .rd_n(rd_n), .mem_addr(mem_addr), .row_sel(row_sel), .col_data(col_data)
  );

  // Reference model written from the requirements.
  int m_act, m_bs, m_g, m_off, m_ch, m_pend, m_lo, m_col, m_row, m_valid, m_rowoff;
  logic [15:0] lit [16];

  function automatic int m_addr();
    return m_ch * 32 + m_g * 2 + m_bs;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 0; m_bs <= 0; m_g <= 0; m_off <= 0; m_ch <= 0; m_pend <= 0;
      m_lo <= 0; m_col <= 0; m_row <= 0; m_valid <= 0; m_rowoff <= 0;
    end else begin
      m_act <= 1;
      if (m_act != 0) m_bs <= 1 - m_bs;
      if (m_act != 0 && m_bs == 0) m_lo <= int'(memf(10'(m_addr())));
      if (m_act != 0 && m_bs == 1) begin
        m_col    <= int'(memf(10'(m_addr()))) * 256 + m_lo;
        m_row    <= (m_g + 15 - m_off) % 16;
        m_valid  <= 1;
        m_rowoff <= m_off;
        if (m_pend != 0 || scroll_tick) begin
          m_pend <= 0;
          m_off  <= (m_off + 1) % 16;
          m_g    <= 0;
          if (m_off == 15) m_ch <= (m_ch + 1) % 32;
        end else begin
          m_g <= (m_g >= m_off) ? 0 : m_g + 1;
        end
      end else if (scroll_tick) begin
        m_pend <= 1;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      logic [15:0] exp_rs;
      exp_rs = (m_valid != 0) ? (16'h1 << m_row) : 16'h0;
      check(rd_n == (m_act == 0), "R9 read strobe", int'(rd_n), int'(m_act == 0));
      check(mem_addr[0] == 1'(m_bs), "R2 byte select", int'(mem_addr[0]), m_bs);
      check(int'(mem_addr[4:1]) == m_g, "R3 glyph row", int'(mem_addr[4:1]), m_g);
      check(int'(mem_addr[9:5]) == m_ch, "R5 char index", int'(mem_addr[9:5]), m_ch);
      check(int'(col_data) == m_col, "R6 row word", int'(col_data), m_col);
      check(row_sel == exp_rs, "R7/R8 row select", int'(row_sel), int'(exp_rs));
      if (m_valid != 0) lit[m_rowoff] = lit[m_rowoff] | row_sel;
    end
  end

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_n == 1'b1, "R1 rd_n in reset", int'(rd_n), 1);
    check(mem_addr == 10'd0, "R1 addr in reset", int'(mem_addr), 0);
    check(row_sel == 16'd0, "R1 row_sel in reset", int'(row_sel), 0);
    check(col_data == 16'd0, "R1 col_data in reset", int'(col_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(row_sel == 16'd0, "R8 dark before first pair", int'(row_sel), 0);
    check(rd_n == 1'b0, "R9 strobe after reset", int'(rd_n), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) lit[k] = 16'h0;
    @(negedge clk);
    reset_check();
    cmp_en = 1'b1;
    // Offset 0 before any tick: only LED row 15 may light (R7).
    repeat (20) @(negedge clk);
    check(row_sel == 16'h8000, "R7 offset zero row", int'(row_sel), 16'h8000);
    for (int t = 0; t < 528; t++) begin
      scroll_tick = 1'b1;
      @(negedge clk);
      scroll_tick = 1'b0;
      repeat (36 + (t % 7)) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(mem_addr[9:5] == 5'd1, "R5 char after 33 wraps", int'(mem_addr[9:5]), 1);
    for (int k = 0; k < 16; k++) begin
      logic [15:0] e;
      e = 16'hFFFF << (15 - k);
      check(lit[k] == e, "R4/R7 lit rows per offset", int'(lit[k]), int'(e));
    end
    cmp_en = 1'b0;
    reset_check();
    cmp_en = 1'b1;
    repeat (40) @(negedge clk);
    check(mem_addr[9:5] == 5'd0, "R1 char cleared by reset", int'(mem_addr[9:5]), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule